// File: doc/BRIEF.md
# Throttle-Gated Trigger Regulator

This block is the central trigger-acceptance stage of a readout controller. On every bunch crossing it takes a physics trigger decision and a request for a calibration or periodic trigger. It also takes throttle requests from the carrier cards of a set of readout boards. A free-running crossing counter advances once per clock and returns to zero on an orbit pulse or after a programmable last value. The block emits a final accept or reject for each crossing a fixed number of clocks later, tagged with the crossing number the decision belongs to.

The throttle requests are merged into one bit per board. If any board is throttling, a physics accept becomes a reject. A special (calibration or periodic) request always yields an accept. The block keeps a registered throttle word that holds the per-board bits and the crossing number at which throttling began. A counter records how many physics accepts were turned into rejects.

Top module: `trigger_regulator`

## Requirements
- R1: While `rst` is high at a clock edge, the following outputs are zero after that edge: `bxId`, `outValid`, `outAccept`, `throttledCount`, `thrBoards`.
- R2: `bxId` rises by one on each clock and goes to 0 on the clock after it has shown `BX_MAX`.
- R3: When `orbitPulse` is high in a cycle, `bxId` is 0 in the next cycle, whatever its current value.
- R4: Board b is throttling when any of its card inputs is high. Its cards are the `cardThrottle` bits at indices b*CARDS_PER_BOARD through b*CARDS_PER_BOARD+CARDS_PER_BOARD-1.
- R5: `thrBoards` shows, one clock later, the per-board throttle bits of the previous cycle.
- R6: `thrStartBx` is loaded with the `bxId` of a cycle in which some board throttles and no board throttled in the cycle before. It keeps that value while throttling goes on, even when other boards join or leave.
- R7: Suppose a crossing has `physTrig` high and no board throttling. `LATENCY` clocks later, `outAccept` is 1 and `outBxId` equals that crossing's `bxId`.
- R8: Suppose a crossing has `physTrig` high, `specTrig` low and at least one board throttling. `LATENCY` clocks later, `outAccept` is 0.
- R9: A crossing with `specTrig` high yields `outAccept` 1 `LATENCY` clocks later, with or without throttling or a physics trigger.
- R10: `throttledCount` rises by exactly one in the clock after each crossing covered by R8. It does not change after any other crossing.
- R11: After reset is released, `outValid` stays 0 for the first `LATENCY`-1 clocks and is 1 from clock `LATENCY` on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz crossing clock |
| rst | input | 1 | Synchronous reset, active high; also clears the throttle counter |
| orbitPulse | input | 1 | Orbit marker; returns the crossing counter to zero |
| physTrig | input | 1 | Physics trigger decision for the current crossing |
| specTrig | input | 1 | Calibration or periodic trigger request for the current crossing |
| cardThrottle | input | NUM_BOARDS*CARDS_PER_BOARD | Throttle requests from all carrier cards, grouped per board |
| bxId | output | 12 | Current crossing number |
| thrBoards | output | NUM_BOARDS | Registered per-board throttle bits of the throttle word |
| thrStartBx | output | 12 | Crossing number at which the current throttle began |
| outValid | output | 1 | Delayed decision is meaningful (pipeline filled since reset) |
| outAccept | output | 1 | Final decision, 1 = accept, 0 = reject |
| outBxId | output | 12 | Crossing number the final decision belongs to |
| throttledCount | output | 32 | Number of physics accepts turned into rejects |

## Verification
The bench builds the block with `BX_MAX` = 15, three boards of two cards each, and `LATENCY` = 3. The short crossing range brings the wrap from the last value back to zero within a few dozen clocks, and lets an orbit pulse be tested part-way through a turn. Two cards per board let the bench show that one card alone throttles its board, and that the board mapping follows the stated indices. A latency of three checks that the crossing tag and the decision travel together through more than one stage, and that the valid flag waits for the whole pipe to fill.

// File: rtl/trig_reg_pkg.sv
package trig_reg_pkg;

  localparam int BX_WIDTH  = 12;
  localparam int CNT_WIDTH = 32;

  // Strobes from control to datapath, one set per crossing
  typedef struct packed {
    logic acceptNow;   // decision for this crossing is accept
    logic convReject;  // a physics accept was vetoed by throttling
    logic thrStart;    // throttling begins in this crossing
  } trigStrobe_t;

  // One slot of the fixed-latency decision pipe
  typedef struct packed {
    logic                valid;
    logic                accept;
    logic [BX_WIDTH-1:0] bx;
  } pipeSlot_t;

endpackage

// File: rtl/board_throttle_merge.sv
module board_throttle_merge #(
  parameter int NUM_BOARDS      = 4,
  parameter int CARDS_PER_BOARD = 4,
  localparam int NUM_CARDS      = NUM_BOARDS * CARDS_PER_BOARD
) (
  input  logic [NUM_CARDS-1:0]  cardThrottle,
  output logic [NUM_BOARDS-1:0] boardThrottle
);

  // R4: each board throttles when any of its cards asks for it
  for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_board
    assign boardThrottle[b] = |cardThrottle[b*CARDS_PER_BOARD +: CARDS_PER_BOARD];
  end

endmodule

// File: rtl/trig_reg_ctrl.sv
module trig_reg_ctrl
  import trig_reg_pkg::*;
#(
  parameter int NUM_BOARDS = 4
) (
  input  logic                  physTrig,
  input  logic                  specTrig,
  input  logic [NUM_BOARDS-1:0] boardThrottle,
  input  logic [NUM_BOARDS-1:0] prevBoardThrottle,
  output trigStrobe_t           strobe
);

  logic anyNow;
  logic anyPrev;

  assign anyNow  = |boardThrottle;
  assign anyPrev = |prevBoardThrottle;

  always_comb begin
    strobe = '0;
    // R9: special request wins over the physics decision and over throttle
    if (specTrig) begin
      strobe.acceptNow = 1'b1;
    end else if (physTrig) begin
      // R7 / R8: physics accept survives only with no throttle
      strobe.acceptNow  = ~anyNow;
      strobe.convReject = anyNow;
    end
    strobe.thrStart = anyNow & ~anyPrev;
  end

  // R8: a vetoed crossing never also carries an accept
  always_comb begin
    a_r8_veto_exclusive : assert (!(strobe.acceptNow && strobe.convReject))
      else $error("accept and veto raised together");
  end

endmodule

// File: rtl/trig_reg_dp.sv
module trig_reg_dp
  import trig_reg_pkg::*;
#(
  parameter int                  NUM_BOARDS = 4,
  parameter logic [BX_WIDTH-1:0] BX_MAX     = 12'd3563,
  parameter int                  LATENCY    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  orbitPulse,
  input  logic [NUM_BOARDS-1:0] boardThrottle,
  input  trigStrobe_t           strobe,
  output logic [BX_WIDTH-1:0]   bxId,
  output logic [NUM_BOARDS-1:0] thrBits,
  output logic [BX_WIDTH-1:0]   thrStartBx,
  output logic                  outValid,
  output logic                  outAccept,
  output logic [BX_WIDTH-1:0]   outBxId,
  output logic [CNT_WIDTH-1:0]  throttledCount
);

  localparam int LAST = LATENCY - 1;

  // Crossing counter (R2, R3)
  always_ff @(posedge clk) begin
    if (rst || orbitPulse || bxId == BX_MAX) bxId <= '0;
    else                                     bxId <= bxId + 1'b1;
  end

  // Throttle word (R5, R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      thrBits    <= '0;
      thrStartBx <= '0;
    end else begin
      thrBits <= boardThrottle;
      if (strobe.thrStart) thrStartBx <= bxId;
    end
  end

  // Veto counter (R10)
  always_ff @(posedge clk) begin
    if (rst)                    throttledCount <= '0;
    else if (strobe.convReject) throttledCount <= throttledCount + 1'b1;
  end

  // Fixed-latency pipe carrying decision and crossing tag together (R7, R11)
  pipeSlot_t pipe [LATENCY];

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= '{valid: 1'b1, accept: strobe.acceptNow, bx: bxId};
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign outValid  = pipe[LAST].valid;
  assign outAccept = pipe[LAST].accept;
  assign outBxId   = pipe[LAST].bx;

  // Assertions next to the logic they guard
  a_r2_bx_step : assert property (@(posedge clk) disable iff (rst)
    (!orbitPulse && bxId != BX_MAX) |=> bxId == $past(bxId) + 1'b1)
    else $error("crossing counter step");

  a_r2_bx_wrap : assert property (@(posedge clk) disable iff (rst)
    (bxId == BX_MAX) |=> bxId == '0)
    else $error("crossing counter wrap");

  a_r3_orbit_clear : assert property (@(posedge clk) disable iff (rst)
    orbitPulse |=> bxId == '0)
    else $error("orbit did not clear counter");

  a_r5_bits_follow : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> thrBits == $past(boardThrottle))
    else $error("throttle word bits");

  a_r6_start_capture : assert property (@(posedge clk) disable iff (rst)
    strobe.thrStart |=> thrStartBx == $past(bxId))
    else $error("throttle start crossing");

  a_r6_start_hold : assert property (@(posedge clk) disable iff (rst)
    !strobe.thrStart |=> $stable(thrStartBx))
    else $error("throttle start moved");

  a_r10_count_step : assert property (@(posedge clk) disable iff (rst)
    strobe.convReject |=> throttledCount == $past(throttledCount) + 32'd1)
    else $error("veto count step");

  a_r10_count_hold : assert property (@(posedge clk) disable iff (rst)
    !strobe.convReject |=> $stable(throttledCount))
    else $error("veto count moved");

endmodule

// File: rtl/trigger_regulator.sv
module trigger_regulator
  import trig_reg_pkg::*;
#(
  parameter int                  NUM_BOARDS      = 4,
  parameter int                  CARDS_PER_BOARD = 4,
  parameter logic [BX_WIDTH-1:0] BX_MAX          = 12'd3563,
  parameter int                  LATENCY         = 4,
  localparam int                 NUM_CARDS       = NUM_BOARDS * CARDS_PER_BOARD
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  orbitPulse,
  input  logic                  physTrig,
  input  logic                  specTrig,
  input  logic [NUM_CARDS-1:0]  cardThrottle,
  output logic [BX_WIDTH-1:0]   bxId,
  output logic [NUM_BOARDS-1:0] thrBoards,
  output logic [BX_WIDTH-1:0]   thrStartBx,
  output logic                  outValid,
  output logic                  outAccept,
  output logic [BX_WIDTH-1:0]   outBxId,
  output logic [CNT_WIDTH-1:0]  throttledCount
);

  logic [NUM_BOARDS-1:0] boardThrottle;
  trigStrobe_t           strobe;

  board_throttle_merge #(
    .NUM_BOARDS      (NUM_BOARDS),
    .CARDS_PER_BOARD (CARDS_PER_BOARD)
  ) u_merge (
    .cardThrottle  (cardThrottle),
    .boardThrottle (boardThrottle)
  );

  trig_reg_ctrl #(
    .NUM_BOARDS (NUM_BOARDS)
  ) u_ctrl (
    .physTrig          (physTrig),
    .specTrig          (specTrig),
    .boardThrottle     (boardThrottle),
    .prevBoardThrottle (thrBoards),
    .strobe            (strobe)
  );

  trig_reg_dp #(
    .NUM_BOARDS (NUM_BOARDS),
    .BX_MAX     (BX_MAX),
    .LATENCY    (LATENCY)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .orbitPulse     (orbitPulse),
    .boardThrottle  (boardThrottle),
    .strobe         (strobe),
    .bxId           (bxId),
    .thrBits        (thrBoards),
    .thrStartBx     (thrStartBx),
    .outValid       (outValid),
    .outAccept      (outAccept),
    .outBxId        (outBxId),
    .throttledCount (throttledCount)
  );

endmodule

// File: tb/trigger_regulator_bench.sv
`timescale 1ns/1ps
module trigger_regulator_bench;

  localparam int         NB  = 3;
  localparam int         CPB = 2;
  localparam logic [11:0] BXM = 12'd15;
  localparam int         LAT = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          orbitPulse;
  logic          physTrig;
  logic          specTrig;
  logic [NB*CPB-1:0] cardThrottle;
  logic [11:0]   bxId;
  logic [NB-1:0] thrBoards;
  logic [11:0]   thrStartBx;
  logic          outValid;
  logic          outAccept;
  logic [11:0]   outBxId;
  logic [31:0]   throttledCount;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  trigger_regulator #(
    .NUM_BOARDS (NB), .CARDS_PER_BOARD (CPB), .BX_MAX (BXM), .LATENCY (LAT)
  ) u_trigger_regulator (
    .clk (clk), .rst (rst), .orbitPulse (orbitPulse), .physTrig (physTrig),
    .specTrig (specTrig), .cardThrottle (cardThrottle), .bxId (bxId),
    .thrBoards (thrBoards), .thrStartBx (thrStartBx), .outValid (outValid),
    .outAccept (outAccept), .outBxId (outBxId), .throttledCount (throttledCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; orbitPulse = 1'b0; physTrig = 1'b0; specTrig = 1'b0; cardThrottle = '0;
    repeat (3) @(negedge clk);
    chk("R1 bxId", bxId, 0);
    chk("R1 outValid", outValid, 0);
    chk("R1 outAccept", outAccept, 0);
    chk("R1 count", throttledCount, 0);
    chk("R1 thrBoards", thrBoards, 0);
    rst = 1'b0;
    // R11: valid after LAT clocks
    repeat (LAT - 1) @(negedge clk);
    chk("R11 not yet valid", outValid, 0);
    @(negedge clk);
    chk("R11 valid", outValid, 1);
  endtask

  task automatic t_count_wrap();
    logic [11:0] prev;
    for (int i = 0; i < 40; i++) begin
      prev = bxId;
      @(negedge clk);
      chk("R2 step/wrap", bxId, (prev == BXM) ? 0 : prev + 1);
    end
  endtask

  task automatic t_orbit();
    while (bxId != 12'd7) @(negedge clk);
    orbitPulse = 1'b1;
    @(negedge clk);
    orbitPulse = 1'b0;
    chk("R3 orbit clears", bxId, 0);
    @(negedge clk);
    chk("R3 resumes", bxId, 1);
  endtask

  // One crossing of stimulus, then checks of counter and delayed decision
  task automatic t_decision(input string req, input logic ph, input logic sp,
                            input logic [NB*CPB-1:0] cards, input logic expAcc,
                            input logic expConv);
    logic [11:0] bx;
    logic [31:0] cnt;
    cardThrottle = cards;
    physTrig = ph; specTrig = sp;
    bx = bxId; cnt = throttledCount;
    @(negedge clk);
    physTrig = 1'b0; specTrig = 1'b0;
    chk({req, " R10 count"}, throttledCount, cnt + (expConv ? 1 : 0));
    repeat (LAT - 1) @(negedge clk);
    chk({req, " accept"}, outAccept, expAcc);
    chk({req, " R7 tag"}, outBxId, bx);
    cardThrottle = '0;
    @(negedge clk);
  endtask

  task automatic t_throttle_word();
    logic [11:0] bx;
    cardThrottle = '0;
    @(negedge clk);
    chk("R5 idle", thrBoards, 0);
    cardThrottle = 6'b000010;  // board 0 card 1
    bx = bxId;
    @(negedge clk);
    chk("R4 board0 from card1", thrBoards, 3'b001);
    chk("R6 start tag", thrStartBx, bx);
    cardThrottle = 6'b010010;  // add board 2 card 0
    @(negedge clk);
    chk("R5 two boards", thrBoards, 3'b101);
    chk("R6 tag held", thrStartBx, bx);
    cardThrottle = 6'b010000;  // board 0 leaves
    @(negedge clk);
    chk("R5 board0 left", thrBoards, 3'b100);
    chk("R6 tag still held", thrStartBx, bx);
    cardThrottle = '0;
    @(negedge clk);
    chk("R5 released", thrBoards, 0);
    cardThrottle = 6'b001000;  // board 1 card 1
    bx = bxId;
    @(negedge clk);
    chk("R4 board1 from card1", thrBoards, 3'b010);
    chk("R6 new start tag", thrStartBx, bx);
    cardThrottle = '0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_count_wrap();
    t_orbit();
    t_decision("R7 physics no throttle", 1'b1, 1'b0, 6'b000000, 1'b1, 1'b0);
    t_decision("R8 physics throttled",   1'b1, 1'b0, 6'b100000, 1'b0, 1'b1);
    t_decision("R8 throttled board1",    1'b1, 1'b0, 6'b000100, 1'b0, 1'b1);
    t_decision("R9 special throttled",   1'b0, 1'b1, 6'b000001, 1'b1, 1'b0);
    t_decision("R9 special plus physics throttled", 1'b1, 1'b1, 6'b000011, 1'b1, 1'b0);
    t_decision("R9 special alone",       1'b0, 1'b1, 6'b000000, 1'b1, 1'b0);
    t_decision("R10 no trigger throttled", 1'b0, 1'b0, 6'b111111, 1'b0, 1'b0);
    t_decision("R7 no trigger",          1'b0, 1'b0, 6'b000000, 1'b0, 1'b0);
    t_throttle_word();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule